// File: doc/BRIEF.md
# Subarray Refresh Conflict Gate

This block sits beside a memory controller's command scheduler and decides, access by access, whether a bank access may go ahead while that bank is refreshing. A refresh only occupies the sense amplifiers of the subarray that holds the refreshed row. It does not touch the bank's data path. So the gate tracks one busy subarray per bank and stalls an access only when it targets that subarray. Accesses to any other subarray of the same bank are granted while the refresh runs.

Refresh starts arrive either addressed to one bank or to all banks at once. Both kinds go through the same check. A build-time option picks where the refreshed subarray index comes from. It can be taken from the refresh request itself. It can also come from a per-bank sequential counter that the gate keeps. Each refresh occupies its subarray for a fixed number of cycles set by a parameter. The cycle in which the refresh start is presented counts as the first of those cycles.

Top module: `subarray_refresh_gate`

## Requirements
- R1: After reset no subarray of any bank is busy, every access is granted, and every per-bank sequential index is 0.
- R2: `acc_grant` and `acc_stall` are never high together, and both are low in any cycle where `acc_valid` is low.
- R3: An access to the busy subarray of a bank stalls for exactly `REF_CYCLES` cycles. The count starts with the cycle the refresh start is presented, and the access is granted from the next cycle on.
- R4: An access to a different subarray of a refreshing bank is granted.
- R5: A single-bank refresh (`ref_all` low) affects only the bank selected by `ref_bank`, and accesses to other banks are granted.
- R6: An all-bank refresh (`ref_all` high) marks one and the same subarray index busy in every bank in the same cycle, and `ref_bank` is then ignored.
- R7: When a refresh start and an access to the same bank and subarray are presented in the same cycle, the access is stalled.
- R8: With `SUB_SOURCE = SUB_FROM_COUNTER`, each bank's refreshed index starts at 0, rises by one with every refresh to that bank, wraps from `NUM_SUBARRAYS-1` to 0, and `ref_sub` has no effect.
- R9: With `SUB_SOURCE = SUB_FROM_COUNTER`, an all-bank refresh uses the current index of bank 0 for every bank, and it sets every bank's next index to that value plus one (wrapped).
- R10: A refresh start to a bank that is already refreshing replaces its busy subarray and restarts the full `REF_CYCLES` duration.
- R11: With `SUB_SOURCE = SUB_FROM_PORT`, the busy subarray is the value on `ref_sub` when the refresh starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_start | input | 1 | Refresh begins in this cycle |
| ref_all | input | 1 | 1: refresh hits all banks, 0: only `ref_bank` |
| ref_bank | input | BANK_W | Bank of a single-bank refresh |
| ref_sub | input | SUB_W | Refreshed subarray when taken from the request |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_bank | input | BANK_W | Bank of the access |
| acc_sub | input | SUB_W | Subarray of the access |
| acc_grant | output | 1 | Access may proceed this cycle |
| acc_stall | output | 1 | Access collides with a refresh and must wait |

## Verification
The bench drives one stimulus into two builds of the gate, one per index source, and compares each against its own model. The first corner is the edge of the busy window. A gate whose counter is off by one stalls one cycle too few or too many at the end of a refresh. A gate that ignores a refresh starting in the same cycle grants a colliding access. Other sequences check that only the correct subarray is blocked. They repeat refreshes to one bank until the sequential index wraps, issue all-bank refreshes after the banks' indices have drifted apart, and restart a refresh on a busy bank. A wrong gate blocks the whole bank, forgets to wrap or wraps early, marks different subarrays in different banks, or keeps the old subarray or the old remaining time after a restart.

// File: rtl/srg_pkg.sv
package srg_pkg;

   typedef enum logic {
      SUB_FROM_PORT    = 1'b0,
      SUB_FROM_COUNTER = 1'b1
   } sub_src_e;

   function automatic int unsigned idx_width(input int unsigned count);
      return (count <= 2) ? 1 : $clog2(count);
   endfunction

endpackage

// File: rtl/srg_bank_slot.sv
module srg_bank_slot
   import srg_pkg::*;
#(
   parameter int unsigned NUM_SUBARRAYS = 8,
   parameter int unsigned REF_CYCLES    = 16,
   localparam int unsigned SUB_W        = idx_width(NUM_SUBARRAYS),
   localparam int unsigned CNT_W        = idx_width(REF_CYCLES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [SUB_W-1:0] start_sub,
   output logic             busy,
   output logic [SUB_W-1:0] busy_sub,
   output logic [SUB_W-1:0] next_ptr
);

   localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(NUM_SUBARRAYS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_sub <= '0;
         next_ptr <= '0;
      end else if (start) begin
         busy_sub <= start_sub;
         next_ptr <= (start_sub == LAST_SUB) ? '0 : start_sub + 1'b1;
      end
   end

   generate
      if (REF_CYCLES == 1) begin : g_single_cycle
         assign busy = 1'b0;
      end else begin : g_timed
         logic             active;
         logic [CNT_W-1:0] remain;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               active <= 1'b0;
               remain <= '0;
            end else if (start) begin
               active <= 1'b1;
               remain <= CNT_W'(REF_CYCLES - 1);
            end else if (active) begin
               remain <= remain - 1'b1;
               if (remain == CNT_W'(1)) begin
                  active <= 1'b0;
               end
            end
         end

         assign busy = active;
      end
   endgenerate

endmodule

// File: rtl/srg_conflict_check.sv
module srg_conflict_check
   import srg_pkg::*;
#(
   parameter int unsigned NUM_BANKS     = 8,
   parameter int unsigned NUM_SUBARRAYS = 8,
   localparam int unsigned BANK_W       = idx_width(NUM_BANKS),
   localparam int unsigned SUB_W        = idx_width(NUM_SUBARRAYS)
) (
   input  logic [BANK_W-1:0]  acc_bank,
   input  logic [SUB_W-1:0]   acc_sub,
   input  logic [NUM_BANKS-1:0] bank_hit,
   input  logic [SUB_W-1:0]   start_sub [NUM_BANKS],
   input  logic [NUM_BANKS-1:0] bank_busy,
   input  logic [SUB_W-1:0]   busy_sub  [NUM_BANKS],
   output logic               conflict
);

   logic starting_here;
   logic held_here;

   always_comb begin
      starting_here = 1'b0;
      held_here     = 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (acc_bank == BANK_W'(b)) begin
            starting_here = bank_hit[b]  && (start_sub[b] == acc_sub);
            held_here     = bank_busy[b] && (busy_sub[b]  == acc_sub);
         end
      end
      conflict = starting_here | held_here;
   end

endmodule

// File: rtl/subarray_refresh_gate.sv
module subarray_refresh_gate
   import srg_pkg::*;
#(
   parameter int unsigned NUM_BANKS     = 8,
   parameter int unsigned NUM_SUBARRAYS = 8,
   parameter int unsigned REF_CYCLES    = 16,
   parameter sub_src_e    SUB_SOURCE    = SUB_FROM_PORT,
   localparam int unsigned BANK_W       = idx_width(NUM_BANKS),
   localparam int unsigned SUB_W        = idx_width(NUM_SUBARRAYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_start,
   input  logic              ref_all,
   input  logic [BANK_W-1:0] ref_bank,
   input  logic [SUB_W-1:0]  ref_sub,
   input  logic              acc_valid,
   input  logic [BANK_W-1:0] acc_bank,
   input  logic [SUB_W-1:0]  acc_sub,
   output logic              acc_grant,
   output logic              acc_stall
);

   generate
      if (NUM_BANKS < 1) begin : g_bad_banks
         $error("subarray_refresh_gate: NUM_BANKS must be at least 1");
      end
      if (NUM_SUBARRAYS < 2) begin : g_bad_subs
         $error("subarray_refresh_gate: NUM_SUBARRAYS must be at least 2");
      end
      if (REF_CYCLES < 1) begin : g_bad_cycles
         $error("subarray_refresh_gate: REF_CYCLES must be at least 1");
      end
   endgenerate

   logic [NUM_BANKS-1:0] bank_hit;
   logic [NUM_BANKS-1:0] bank_busy;
   logic [SUB_W-1:0]     start_sub [NUM_BANKS];
   logic [SUB_W-1:0]     busy_sub  [NUM_BANKS];
   logic [SUB_W-1:0]     next_ptr  [NUM_BANKS];
   logic                 conflict;

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         assign bank_hit[b] = ref_start && (ref_all || (ref_bank == BANK_W'(b)));

         if (SUB_SOURCE == SUB_FROM_PORT) begin : g_from_port
            assign start_sub[b] = ref_sub;
         end else begin : g_from_counter
            assign start_sub[b] = ref_all ? next_ptr[0] : next_ptr[b];
         end

         srg_bank_slot #(
            .NUM_SUBARRAYS (NUM_SUBARRAYS),
            .REF_CYCLES    (REF_CYCLES)
         ) i_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (bank_hit[b]),
            .start_sub (start_sub[b]),
            .busy      (bank_busy[b]),
            .busy_sub  (busy_sub[b]),
            .next_ptr  (next_ptr[b])
         );
      end
   endgenerate

   srg_conflict_check #(
      .NUM_BANKS     (NUM_BANKS),
      .NUM_SUBARRAYS (NUM_SUBARRAYS)
   ) i_conflict (
      .acc_bank  (acc_bank),
      .acc_sub   (acc_sub),
      .bank_hit  (bank_hit),
      .start_sub (start_sub),
      .bank_busy (bank_busy),
      .busy_sub  (busy_sub),
      .conflict  (conflict)
   );

   assign acc_grant = acc_valid & ~conflict;
   assign acc_stall = acc_valid &  conflict;

endmodule

// File: rtl/srg_checker.sv
module srg_checker #(
   parameter int unsigned NUM_BANKS  = 8,
   parameter int unsigned BANK_W     = 3,
   parameter int unsigned SUB_W      = 3,
   parameter int unsigned REF_CYCLES = 16,
   parameter bit          FROM_PORT  = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ref_start,
   input logic              ref_all,
   input logic [BANK_W-1:0] ref_bank,
   input logic [SUB_W-1:0]  ref_sub,
   input logic              acc_valid,
   input logic [BANK_W-1:0] acc_bank,
   input logic [SUB_W-1:0]  acc_sub,
   input logic              acc_grant,
   input logic              acc_stall,
   input logic [NUM_BANKS-1:0] bank_busy
);

   localparam bit TIMED = (REF_CYCLES > 1);

   AST_GRANT_STALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_grant && acc_stall)); // R2

   AST_QUIET_WITHOUT_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (!acc_grant && !acc_stall)); // R2

   AST_STALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      acc_stall |-> (ref_start || (|bank_busy))); // R3

   AST_TARGET_BANK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (TIMED && $past(ref_start) && !$past(ref_all)) |-> bank_busy[$past(ref_bank)]); // R5

   AST_ALL_BANKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (TIMED && $past(ref_start) && $past(ref_all)) |-> (&bank_busy)); // R6

   AST_START_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (FROM_PORT && ref_start && acc_valid && (ref_all || (ref_bank == acc_bank))
       && (ref_sub == acc_sub)) |-> acc_stall); // R7

endmodule

bind subarray_refresh_gate srg_checker #(
   .NUM_BANKS  (NUM_BANKS),
   .BANK_W     (BANK_W),
   .SUB_W      (SUB_W),
   .REF_CYCLES (REF_CYCLES),
   .FROM_PORT  (SUB_SOURCE == srg_pkg::SUB_FROM_PORT)
) i_srg_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .ref_start (ref_start),
   .ref_all   (ref_all),
   .ref_bank  (ref_bank),
   .ref_sub   (ref_sub),
   .acc_valid (acc_valid),
   .acc_bank  (acc_bank),
   .acc_sub   (acc_sub),
   .acc_grant (acc_grant),
   .acc_stall (acc_stall),
   .bank_busy (bank_busy)
);

// File: tb/test_subarray_refresh_gate.sv
module test_subarray_refresh_gate;
   import srg_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NB = 4;
   localparam int NS = 4;
   localparam int DUR = 6;
   localparam int BW = 2;
   localparam int SW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ref_start = 1'b0;
   logic          ref_all = 1'b0;
   logic [BW-1:0] ref_bank = '0;
   logic [SW-1:0] ref_sub = '0;
   logic          acc_valid = 1'b0;
   logic [BW-1:0] acc_bank = '0;
   logic [SW-1:0] acc_sub = '0;
   logic          grant_p, stall_p, grant_c, stall_c;

   int total = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   subarray_refresh_gate #(
      .NUM_BANKS(NB), .NUM_SUBARRAYS(NS), .REF_CYCLES(DUR), .SUB_SOURCE(SUB_FROM_PORT)
   ) i_subarray_refresh_gate (
      .clk(clk), .rst_n(rst_n), .ref_start(ref_start), .ref_all(ref_all),
      .ref_bank(ref_bank), .ref_sub(ref_sub), .acc_valid(acc_valid),
      .acc_bank(acc_bank), .acc_sub(acc_sub), .acc_grant(grant_p), .acc_stall(stall_p)
   );

   subarray_refresh_gate #(
      .NUM_BANKS(NB), .NUM_SUBARRAYS(NS), .REF_CYCLES(DUR), .SUB_SOURCE(SUB_FROM_COUNTER)
   ) i_subarray_refresh_gate_ctr (
      .clk(clk), .rst_n(rst_n), .ref_start(ref_start), .ref_all(ref_all),
      .ref_bank(ref_bank), .ref_sub(ref_sub), .acc_valid(acc_valid),
      .acc_bank(acc_bank), .acc_sub(acc_sub), .acc_grant(grant_c), .acc_stall(stall_c)
   );

   // model state: cycles still busy after the current one, busy subarray per build, counter
   int rem [NB];
   int sub_p [NB];
   int sub_c [NB];
   int ptr [NB];

   bit [3:0] q_exp [$];
   string    q_tag [$];

   task automatic check(input string tag, input string who, input bit act, input bit exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s [%s] actual=%0b expected=%0b", tag, who, act, exp);
      end
   endtask

   // scoreboard monitor: compares away from the active edge
   always @(negedge clk) begin
      if (q_exp.size() > 0) begin
         bit [3:0] e;
         string t;
         e = q_exp.pop_front();
         t = q_tag.pop_front();
         check(t, "port grant",    grant_p, e[3]);
         check(t, "port stall",    stall_p, e[2]);
         check(t, "counter grant", grant_c, e[1]);
         check(t, "counter stall", stall_c, e[0]);
      end
   end

   task automatic step(input bit rs, input bit ra, input int rb, input int rsub,
                       input bit av, input int ab, input int asub, input string tag);
      bit hit, cp, cc;
      int sc, base0;
      @(posedge clk);
      #1;
      ref_start = rs;  ref_all = ra;  ref_bank = BW'(rb);  ref_sub = SW'(rsub);
      acc_valid = av;  acc_bank = BW'(ab); acc_sub = SW'(asub);
      hit = rs && (ra || rb == ab);
      sc  = ra ? ptr[0] : ptr[ab];
      cp  = av && ((hit && rsub == asub) || (rem[ab] > 0 && sub_p[ab] == asub));
      cc  = av && ((hit && sc == asub)   || (rem[ab] > 0 && sub_c[ab] == asub));
      q_exp.push_back({av && !cp, cp, av && !cc, cc});
      q_tag.push_back(tag);
      base0 = ptr[0];
      for (int b = 0; b < NB; b++) begin
         if (rem[b] > 0) rem[b]--;
      end
      for (int b = 0; b < NB; b++) begin
         if (rs && (ra || rb == b)) begin
            int s;
            s = ra ? base0 : ptr[b];
            rem[b]   = DUR - 1;
            sub_p[b] = rsub;
            sub_c[b] = s;
            ptr[b]   = (s == NS - 1) ? 0 : s + 1;
         end
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, "R2 idle cycle outputs low");
   endtask

   initial begin
      for (int b = 0; b < NB; b++) begin
         rem[b] = 0; sub_p[b] = 0; sub_c[b] = 0; ptr[b] = 0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: nothing busy after reset
      for (int b = 0; b < NB; b++)
         for (int s = 0; s < NS; s++)
            step(0, 0, 0, 0, 1, b, s, "R1 reset state grants every access");
      idle(1);

      // R7/R11: per-bank start to bank 1, subarray 2, colliding access in the same cycle
      step(1, 0, 1, 2, 1, 1, 2, "R7 start wins over same-cycle access");
      for (int k = 0; k < DUR + 1; k++)
         step(0, 0, 0, 0, 1, 1, 2, "R3 stall window on refreshing subarray");

      // R7 counter build: bank 1 index is now 1
      step(1, 0, 1, 0, 1, 1, 1, "R7 counter start wins same cycle");
      for (int k = 0; k < DUR; k++)
         step(0, 0, 0, 0, 1, 1, k % NS, "R4 other subarrays of refreshing bank");
      idle(1);

      // R5: single-bank refresh leaves other banks alone
      step(1, 0, 2, 1, 1, 3, 1, "R5 other bank unaffected");
      for (int k = 0; k < DUR; k++)
         step(0, 0, 0, 0, 1, (k % 2 == 0) ? 3 : 2, 1, "R5 busy bank vs neighbour");

      // R8: repeated refreshes of bank 3 with ref_sub varying, through a wrap
      for (int n = 0; n < NS + 2; n++) begin
         step(1, 0, 3, NS - 1 - (n % NS), 0, 0, 0, "R8 refresh issue");
         for (int s = 0; s < NS; s++)
            step(0, 0, 0, 0, 1, 3, s, "R8 sequential index with wrap");
         idle(DUR);
      end

      // R6/R9: all-bank refresh after the indices have drifted apart
      step(1, 1, 3, 2, 1, 0, 2, "R6 all-bank same-cycle collision");
      for (int b = 0; b < NB; b++)
         step(0, 0, 0, 0, 1, b, 2, "R6 same index busy in every bank");
      idle(DUR);
      step(1, 1, 0, 1, 0, 0, 0, "R9 all-bank issue");
      for (int b = 0; b < NB; b++)
         step(0, 0, 0, 0, 1, b, b % NS, "R9 bank 0 index used everywhere");
      idle(DUR);
      step(1, 0, 2, 0, 0, 0, 0, "R9 per-bank after realign");
      for (int s = 0; s < NS; s++)
         step(0, 0, 0, 0, 1, 2, s, "R9 realigned next index");
      idle(DUR);

      // R10: restart on a busy bank
      step(1, 0, 2, 0, 0, 0, 0, "R10 first refresh");
      step(0, 0, 0, 0, 1, 2, 0, "R10 first subarray busy");
      step(1, 0, 2, 3, 1, 2, 3, "R10 restart collision");
      for (int k = 0; k < DUR + 1; k++)
         step(0, 0, 0, 0, 1, 2, (k % 2 == 0) ? 0 : 3, "R10 replaced subarray and duration");

      // R2: no access while refreshing
      step(1, 1, 0, 0, 0, 0, 0, "R2 no access during refresh");
      idle(2);
      step(0, 0, 0, 0, 1, 0, 0, "R3 window tail");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule